// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a 24-bit down-counter that produces a regular time base for a processor subsystem. Software sets a period in a reload register and turns the counter on. The counter then steps down once per selected clock event. When it reaches zero, the next step loads the period again. Each step from 1 to 0 marks the end of a period. That step sets a sticky status flag and, if tick interrupts are enabled, sends a one-cycle exception request to the interrupt controller.

Access goes through a simple synchronous register bus. Writes take effect at the clock edge. Read data is combinational while the read strobe is high. The read strobe lets a read of the control word clear the status flag. Steps come either from every core-clock cycle or from a single-cycle tick input that an external divider produces in the core-clock domain.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous active-low reset, the control word, the reload value and the counter all read 0, and the exception request is low.
- R2: Byte offset 0x10 holds the control word. Bit 0 turns counting on, bit 1 enables the tick exception, bit 2 selects the core clock (1) or the tick input (0), and bit 16 is the status flag. Bits 0 to 2 read back as written. Bit 16 ignores writes. All other bits read 0.
- R3: Byte offset 0x14 holds the reload value and byte offset 0x18 the counter. Only the low 24 bits are stored, bits 31:24 read 0, and an unmapped offset reads 0.
- R4: While counting is on with the core clock selected, the counter drops by one every cycle. A step taken at zero loads the reload value.
- R5: With the tick input selected, the counter moves only in cycles where the tick input is high.
- R6: A step from 1 to 0 sets the status flag. A read of the control word returns the flag and then clears it.
- R7: A write of any data to offset 0x18 forces the counter to 0 and clears the status flag.
- R8: With bit 1 set, each 1-to-0 step raises the exception request for exactly one cycle, starting the cycle after that step's edge. With bit 1 clear, the request never rises.
- R9: Zeroing the counter by a bus write never raises the exception request or sets the flag, even when the write lands on the edge where the counter is at 1.
- R10: With a reload value of 0, the counter stays at 0 and neither the flag nor the exception request is ever raised.
- R11: While counting is off, the counter holds its value.
- R12: When a 1-to-0 step and a control-word read fall on the same edge, the read returns the old flag and the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_re | input | 1 | Read strobe; qualifies read data and read side effects |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_re is high |
| alt_tick | input | 1 | Single-cycle step enable used when the core clock is not selected |
| tick_irq | output | 1 | One-cycle tick exception request |

## Verification
The bound checker checks these rules on every cycle: the request is never longer than one cycle, a counter write zeroes the counter and never raises the request, the counter holds while counting is off, it decrements by exactly one on the core clock, it stays at zero under a zero reload, and the top byte of a wide read is zero. Several behaviours only the bench scenarios can show. These are the ordering of reload after zero, the exact cycle of the request, the flag's read-and-clear sequence, stepping on the tick input, and the same-edge contest between a flag set and a control read.

// File: rtl/tick_pkg.sv
// Shared field positions and the control-word type of the tick timer.
// Assumes a 32-bit register bus; positions are what software decodes.
package tick_pkg;

    localparam int CTRL_RUN_BIT   = 0;
    localparam int CTRL_IRQEN_BIT = 1;
    localparam int CTRL_CLKSEL_BIT = 2;
    localparam int CTRL_FLAG_BIT  = 16;

    typedef struct packed {
        logic clk_core;  // 1: step every core cycle, 0: step on alt_tick
        logic irq_en;    // raise the request on a 1-to-0 step
        logic run;       // counting on
    } tick_ctrl_t;

endpackage

// File: rtl/tick_regs.sv
// Register bank and bus decode of the tick timer.
// Holds the control bits and the reload value, builds read data and the
// two side-effect strobes (counter clear on write, flag clear on read).
// Assumes DATA_W > CNT_W and that reads return data in the strobe cycle.
module tick_regs
    import tick_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter logic [ADDR_W-1:0] OFF_CTRL   = 'h10,
    parameter logic [ADDR_W-1:0] OFF_RELOAD = 'h14,
    parameter logic [ADDR_W-1:0] OFF_CUR    = 'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cur_val,
    input  logic              cnt_flag,
    output tick_ctrl_t        ctrl,
    output logic [CNT_W-1:0]  reload_val,
    output logic              cur_clr,
    output logic              flag_rd
);

    localparam int PAD_W = DATA_W - CNT_W;

    logic hit_ctrl, hit_reload, hit_cur;
    logic unused_wdata_hi;

    // Address decode of the three registers.
    always_comb begin
        hit_ctrl   = (bus_addr == OFF_CTRL);
        hit_reload = (bus_addr == OFF_RELOAD);
        hit_cur    = (bus_addr == OFF_CUR);
    end

    assign cur_clr = bus_we & hit_cur;
    assign flag_rd = bus_re & hit_ctrl;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

    // Control bits: writable fields only, the flag lives in the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (bus_we && hit_ctrl) begin
            ctrl.run      <= bus_wdata[CTRL_RUN_BIT];
            ctrl.irq_en   <= bus_wdata[CTRL_IRQEN_BIT];
            ctrl.clk_core <= bus_wdata[CTRL_CLKSEL_BIT];
        end
    end

    // Reload value: low CNT_W bits of the write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_val <= '0;
        end else if (bus_we && hit_reload) begin
            reload_val <= bus_wdata[CNT_W-1:0];
        end
    end

    // Read data mux; zero outside the strobe and for unmapped offsets.
    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (hit_ctrl) begin
                bus_rdata[CTRL_RUN_BIT]    = ctrl.run;
                bus_rdata[CTRL_IRQEN_BIT]  = ctrl.irq_en;
                bus_rdata[CTRL_CLKSEL_BIT] = ctrl.clk_core;
                bus_rdata[CTRL_FLAG_BIT]   = cnt_flag;
            end else if (hit_reload) begin
                bus_rdata = {{PAD_W{1'b0}}, reload_val};
            end else if (hit_cur) begin
                bus_rdata = {{PAD_W{1'b0}}, cur_val};
            end
        end
    end

endmodule

// File: rtl/tick_counter.sv
// Down-counter core: step selection, reload at zero, sticky flag and the
// one-cycle exception request. A bus clear beats a step on the same edge
// and suppresses the flag and request; a 1-to-0 step beats a flag read.
module tick_counter
    import tick_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tick_ctrl_t       ctrl,
    input  logic             alt_tick,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             cur_clr,
    input  logic             flag_rd,
    output logic [CNT_W-1:0] cur_val,
    output logic             cnt_flag,
    output logic             tick_irq
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic step, at_zero, hit_one;

    // Step enable: every cycle on the core clock, else on the tick input.
    always_comb begin
        step    = ctrl.run & (ctrl.clk_core | alt_tick);
        at_zero = (cur_val == '0);
        hit_one = step & (cur_val == CNT_ONE) & ~cur_clr;
    end

    // Counter: bus clear, else reload at zero, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_val <= '0;
        end else if (cur_clr) begin
            cur_val <= '0;
        end else if (step) begin
            cur_val <= at_zero ? reload_val : cur_val - CNT_ONE;
        end
    end

    // Sticky flag: set by a 1-to-0 step, cleared by a read or a bus clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_flag <= 1'b0;
        end else if (cur_clr) begin
            cnt_flag <= 1'b0;
        end else if (hit_one) begin
            cnt_flag <= 1'b1;
        end else if (flag_rd) begin
            cnt_flag <= 1'b0;
        end
    end

    // Exception request: one cycle after each enabled 1-to-0 step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_irq <= 1'b0;
        end else begin
            tick_irq <= hit_one & ctrl.irq_en;
        end
    end

endmodule

// File: rtl/tick_timer.sv
// Top of the periodic tick timer: register bank plus down-counter core.
// Assumes bus and alt_tick are synchronous to clk.
module tick_timer
    import tick_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter logic [ADDR_W-1:0] OFF_CTRL   = 'h10,
    parameter logic [ADDR_W-1:0] OFF_RELOAD = 'h14,
    parameter logic [ADDR_W-1:0] OFF_CUR    = 'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              alt_tick,
    output logic              tick_irq
);

    tick_ctrl_t       ctrl;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cur_val;
    logic             cnt_flag;
    logic             cur_clr;
    logic             flag_rd;

    tick_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .OFF_CTRL(OFF_CTRL), .OFF_RELOAD(OFF_RELOAD), .OFF_CUR(OFF_CUR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cur_val(cur_val), .cnt_flag(cnt_flag),
        .ctrl(ctrl), .reload_val(reload_val),
        .cur_clr(cur_clr), .flag_rd(flag_rd)
    );

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .alt_tick(alt_tick),
        .reload_val(reload_val), .cur_clr(cur_clr), .flag_rd(flag_rd),
        .cur_val(cur_val), .cnt_flag(cnt_flag), .tick_irq(tick_irq)
    );

endmodule

// File: rtl/tick_timer_chk.sv
// Property checker for tick_timer, attached by bind below.
module tick_timer_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter logic [ADDR_W-1:0] OFF_RELOAD = 'h14,
    parameter logic [ADDR_W-1:0] OFF_CUR    = 'h18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic              bus_re,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tick_irq,
    input logic              run,
    input logic              clk_core,
    input logic [CNT_W-1:0]  cur_val,
    input logic [CNT_W-1:0]  reload_val
);

    logic cur_wr, rel_wr;
    assign cur_wr = bus_we && (bus_addr == OFF_CUR);
    assign rel_wr = bus_we && (bus_addr == OFF_RELOAD);

    // R8
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |=> !tick_irq);

    // R9
    sw_clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> !tick_irq);

    // R7
    sw_clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> (cur_val == '0));

    // R11
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cur_wr) |=> $stable(cur_val));

    // R4
    core_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && clk_core && !cur_wr && cur_val != '0)
            |=> (cur_val == $past(cur_val) - CNT_W'(1)));

    // R10
    zero_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_val == '0 && reload_val == '0 && !rel_wr) |=> (cur_val == '0));

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && (bus_addr == OFF_RELOAD || bus_addr == OFF_CUR))
            |-> (bus_rdata[DATA_W-1:CNT_W] == '0));

endmodule

bind tick_timer tick_timer_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .OFF_RELOAD(OFF_RELOAD), .OFF_CUR(OFF_CUR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .tick_irq(tick_irq),
    .run(ctrl.run), .clk_core(ctrl.clk_core),
    .cur_val(cur_val), .reload_val(reload_val)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;

    localparam logic [11:0] A_CTRL = 12'h010;
    localparam logic [11:0] A_REL  = 12'h014;
    localparam logic [11:0] A_CUR  = 12'h018;
    localparam int NVEC = 8;
    // {op(1=write,2=read-check), addr, wdata, expected}
    localparam logic [77:0] VEC [NVEC] = '{
        {2'd1, 12'h010, 32'h0001_0006, 32'h0},           // R2 flag bit write
        {2'd2, 12'h010, 32'h0,         32'h0000_0006},   // R2 readback
        {2'd1, 12'h014, 32'hFF12_3456, 32'h0},
        {2'd2, 12'h014, 32'h0,         32'h0012_3456},   // R3 upper zero
        {2'd2, 12'h018, 32'h0,         32'h0},           // R3 counter idle
        {2'd2, 12'h01C, 32'h0,         32'h0},           // R3 unmapped
        {2'd1, 12'h010, 32'h0,         32'h0},
        {2'd2, 12'h010, 32'h0,         32'h0}            // R2 cleared
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alt_tick = 1'b0;
    logic        tick_irq;

    int checks = 0;
    int errors = 0;
    int irq_total = 0;
    int base;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alt_tick(alt_tick), .tick_irq(tick_irq)
    );

    always @(negedge clk) if (tick_irq) irq_total <= irq_total + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdx(input logic [11:0] a, output logic [31:0] d);
        bus_re = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse();
        alt_tick = 1'b1;
        @(negedge clk);
        alt_tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'b0, tick_irq}, 32'h0);
        rdx(A_CTRL, rd); check("R1 ctrl", rd, 32'h0);
        rdx(A_REL, rd);  check("R1 reload", rd, 32'h0);
        rdx(A_CUR, rd);  check("R1 counter", rd, 32'h0);

        // Vector table: register layout (R2, R3)
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][77:76] == 2'd1) begin
                wr(VEC[v][75:64], VEC[v][63:32]);
            end else begin
                rdx(VEC[v][75:64], rd);
                check($sformatf("table entry %0d (R2/R3)", v), rd, VEC[v][31:0]);
            end
        end

        // R4 / R8: core-clock counting, reload after zero, request timing
        wr(A_REL, 32'd5);
        wr(A_CUR, 32'd0);
        base = irq_total;
        wr(A_CTRL, 32'h7);
        bus_re = 1'b1; bus_addr = A_CUR;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            #1;
            check($sformatf("R4 count k=%0d", k), bus_rdata, (k <= 6) ? 32'(6 - k) : 32'(12 - k));
            check($sformatf("R8 irq k=%0d", k), {31'b0, tick_irq}, (k == 6) ? 32'h1 : 32'h0);
        end
        bus_re = 1'b0;

        // R6 flag read returns set, then cleared
        rdx(A_CTRL, rd); check("R6 flag set", rd, 32'h0001_0007);
        rdx(A_CTRL, rd); check("R6 flag cleared by read", rd, 32'h0000_0007);

        // R7 / R11: clear while running, then hold when off
        idle(8);
        wr(A_CUR, 32'h00AB_CDEF);
        wr(A_CTRL, 32'h0);
        rdx(A_CTRL, rd); check("R7 flag cleared by counter write", rd, 32'h0);
        rdx(A_CUR, rd);  check("R11 held after stop", rd, 32'd5);
        idle(5);
        rdx(A_CUR, rd);  check("R11 still held", rd, 32'd5);
        wr(A_CUR, 32'hFFFF_FFFF);
        rdx(A_CUR, rd);  check("R7 any data zeroes", rd, 32'h0);

        // R9: software clear on the edge where the counter is at 1
        wr(A_REL, 32'd2);
        base = irq_total;
        wr(A_CTRL, 32'h7);
        idle(2);
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'h0);
        idle(2);
        check("R9 no request on clear", 32'(irq_total - base), 32'h0);
        rdx(A_CTRL, rd); check("R9 no flag on clear", rd, 32'h0);

        // R8: tick exception disabled
        wr(A_REL, 32'd3);
        wr(A_CUR, 32'h0);
        base = irq_total;
        wr(A_CTRL, 32'h5);
        idle(12);
        check("R8 no request when disabled", 32'(irq_total - base), 32'h0);
        rdx(A_CTRL, rd); check("R8 flag still sets", rd, 32'h0001_0005);
        wr(A_CTRL, 32'h0);

        // R10: zero reload
        wr(A_REL, 32'd0);
        wr(A_CUR, 32'h0);
        base = irq_total;
        wr(A_CTRL, 32'h7);
        idle(20);
        check("R10 no request", 32'(irq_total - base), 32'h0);
        rdx(A_CUR, rd);  check("R10 counter stays 0", rd, 32'h0);
        rdx(A_CTRL, rd); check("R10 no flag", rd, 32'h0000_0007);
        wr(A_CTRL, 32'h0);

        // R5 / R12: tick-input stepping and same-edge flag contest
        wr(A_REL, 32'd3);
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'h1);
        idle(4);
        rdx(A_CUR, rd); check("R5 no step without tick", rd, 32'h0);
        pulse();
        idle(2);
        rdx(A_CUR, rd); check("R5 reload on tick", rd, 32'd3);
        pulse();
        pulse();
        rdx(A_CUR, rd); check("R5 two ticks", rd, 32'd1);
        bus_re = 1'b1; bus_addr = A_CTRL; alt_tick = 1'b1;
        #1 rd = bus_rdata;
        check("R12 read returns old flag", rd, 32'h1);
        @(negedge clk);
        bus_re = 1'b0; alt_tick = 1'b0;
        rdx(A_CTRL, rd); check("R12 flag set wins", rd, 32'h0001_0001);
        rdx(A_CUR, rd);  check("R5 reached zero", rd, 32'h0);

        finish_run();
    end

endmodule